// File: doc/BRIEF.md
# AHB-Lite Two-Cycle Error Response Controller

This block owns the response side of an AHB-Lite slave: it drives the ready-out and response lines back to the master. Normal transfers finish with an OKAY response and no wait states. If the slave's decode logic flags a transfer as bad, the block answers with a two-cycle ERROR response. Examples of a bad transfer are an address that hits no register, or a write into a read-only window. In the first ERROR cycle ready-out is held low. In the second it is released high. This gives the master one full cycle to see the error before the bus moves on.

The error flag comes from the decode logic. It is qualified with the same signals that qualify the address phase. The block captures it at the clock edge where a selected NONSEQ or SEQ transfer is accepted with the bus ready high. The response then appears in the following cycles, because the outputs are registered.

After an error, the master may abandon its burst. Bus ownership may also change in the middle of a burst. In both cases the block makes no assumptions: it serves whatever transfer it sees next. The decoding of error conditions, the data storage and the read-data multiplexing are handled elsewhere in the slave.

Top module: `ahb_errresp_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rdy_out` is 1 and `resp` carries the OKAY code.
- R2: A transfer is accepted when `sel` is 1, `trans` is NONSEQ (2'b10) or SEQ (2'b11), `rdy_in` is 1 and the block is not in its first ERROR cycle. If `err_req` is 0 at acceptance, the next cycle shows `rdy_out`=1 with OKAY (zero wait states).
- R3: If `err_req` is 1 at acceptance, the next cycle shows `rdy_out`=0 with the ERROR code.
- R4: The cycle after a cycle with `rdy_out`=0 always shows `rdy_out`=1 with the ERROR code.
- R5: `err_req` has no effect when the transfer is not accepted: IDLE (2'b00), BUSY (2'b01), `sel`=0 or `rdy_in`=0. The next cycle then shows `rdy_out`=1 with OKAY, unless the block is in its first ERROR cycle.
- R6: A transfer accepted during the second ERROR cycle is served at once. An error request gives a new first ERROR cycle next; otherwise OKAY follows.
- R7: The first ERROR cycle never lasts longer than one cycle, whatever the inputs show during it.
- R8: The response encoding is OKAY = 0 and ERROR = 1, zero-extended to RESP_W bits. With RESP_W=1 this is 1'b0 and 1'b1; with RESP_W=2 it is 2'b00 and 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Slave select from the address decoder |
| trans | input | TRANS_W | Transfer type of the address phase |
| rdy_in | input | 1 | Bus-wide ready; high when the previous transfer completes |
| err_req | input | 1 | Error condition for the transfer currently in its address phase |
| rdy_out | output | 1 | Ready-out driven back to the bus |
| resp | output | RESP_W | Transfer response (OKAY or ERROR) |

## Verification
Two functions can fall in the same cycle: the release of an ERROR response in its second cycle, and the acceptance of the next transfer. The bench provokes this overlap by first steering the block into its second ERROR cycle. It then applies every combination of select, transfer type, bus ready and error request. Each following cycle is judged against a state model written directly from the requirements.

The same sweep is also run from the idle state and from the first ERROR cycle. Running it from the first ERROR cycle shows that inputs offered there are ignored.

// File: rtl/ahb_errresp_pkg.sv
package ahb_errresp_pkg;

   typedef enum logic [1:0] {
      ST_OKAY     = 2'd0,
      ST_ERR_HOLD = 2'd1,
      ST_ERR_DONE = 2'd2
   } resp_state_e;

   localparam logic [1:0] TR_IDLE = 2'b00;
   localparam logic [1:0] TR_BUSY = 2'b01;
   localparam logic [1:0] TR_NSEQ = 2'b10;
   localparam logic [1:0] TR_SEQ  = 2'b11;

endpackage

// File: rtl/ahb_xfer_qualify.sv
module ahb_xfer_qualify
   import ahb_errresp_pkg::*;
#(
   parameter int TRANS_W = 2
) (
   input  logic               sel,
   input  logic [TRANS_W-1:0] trans,
   input  logic               rdy_in,
   input  logic               err_req,
   input  logic               in_hold,
   output logic               acc_ok,
   output logic               acc_err
);

   if (TRANS_W != 2) begin : g_bad_trans_w
      $error("ahb_xfer_qualify: TRANS_W must be 2");
   end

   logic active;
   logic accept;

   always_comb begin
      active = (trans == TR_NSEQ) || (trans == TR_SEQ);
      accept = sel && active && rdy_in && !in_hold;
      acc_ok  = accept && !err_req;
      acc_err = accept && err_req;
   end

endmodule

// File: rtl/ahb_errresp_fsm.sv
module ahb_errresp_fsm
   import ahb_errresp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        acc_ok,
   input  logic        acc_err,
   output resp_state_e state,
   output logic        in_hold
);

   resp_state_e state_nx;

   always_comb begin
      state_nx = ST_OKAY;
      unique case (state)
         ST_ERR_HOLD: state_nx = ST_ERR_DONE;
         ST_OKAY,
         ST_ERR_DONE: state_nx = acc_err ? ST_ERR_HOLD : ST_OKAY;
         default:     state_nx = ST_OKAY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_OKAY;
      else        state <= state_nx;
   end

   assign in_hold = (state == ST_ERR_HOLD);

   // R7: the hold state is left after one cycle
   p_hold_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ERR_HOLD) |=> (state == ST_ERR_DONE));

   // R2: a clean accept never enters an error state
   p_clean_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ok && state != ST_ERR_HOLD) |=> (state == ST_OKAY));

   // acc_ok is not otherwise used here; this keeps the input from being unused.
   logic unused_ok;
   assign unused_ok = acc_ok;

endmodule

// File: rtl/ahb_resp_encode.sv
module ahb_resp_encode
   import ahb_errresp_pkg::*;
#(
   parameter int RESP_W = 1
) (
   input  resp_state_e       state,
   output logic              rdy_out,
   output logic [RESP_W-1:0] resp
);

   logic is_err;

   always_comb begin
      rdy_out = (state != ST_ERR_HOLD);
      is_err  = (state == ST_ERR_HOLD) || (state == ST_ERR_DONE);
   end

   if (RESP_W == 1) begin : g_lite
      assign resp = is_err;
   end else if (RESP_W == 2) begin : g_full
      assign resp = {1'b0, is_err};
   end else begin : g_bad_resp_w
      $error("ahb_resp_encode: RESP_W must be 1 or 2");
   end

endmodule

// File: rtl/ahb_errresp_ctrl.sv
module ahb_errresp_ctrl
   import ahb_errresp_pkg::*;
#(
   parameter int TRANS_W = 2,
   parameter int RESP_W  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel,
   input  logic [TRANS_W-1:0] trans,
   input  logic               rdy_in,
   input  logic               err_req,
   output logic               rdy_out,
   output logic [RESP_W-1:0]  resp
);

   localparam logic [RESP_W-1:0] RSP_OKAY = RESP_W'(0);
   localparam logic [RESP_W-1:0] RSP_ERR  = RESP_W'(1);

   logic        acc_ok;
   logic        acc_err;
   logic        in_hold;
   resp_state_e state;

   ahb_xfer_qualify #(.TRANS_W(TRANS_W)) i_qual (
      .sel     (sel),
      .trans   (trans),
      .rdy_in  (rdy_in),
      .err_req (err_req),
      .in_hold (in_hold),
      .acc_ok  (acc_ok),
      .acc_err (acc_err)
   );

   ahb_errresp_fsm i_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_ok  (acc_ok),
      .acc_err (acc_err),
      .state   (state),
      .in_hold (in_hold)
   );

   ahb_resp_encode #(.RESP_W(RESP_W)) i_enc (
      .state   (state),
      .rdy_out (rdy_out),
      .resp    (resp)
   );

   logic accept_port;
   assign accept_port = sel && trans[1] && rdy_in && rdy_out;

   // R3: an error request at acceptance gives a low ready with ERROR next
   p_err_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_port && err_req) |=> (!rdy_out && resp == RSP_ERR));

   // R3: ready is only held low while ERROR is signalled
   p_low_is_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_out |-> (resp == RSP_ERR));

   // R4: the second ERROR cycle releases ready
   p_err_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_out |=> (rdy_out && resp == RSP_ERR));

   // R2: a clean transfer completes with no wait state
   p_ok_zero_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_port && !err_req) |=> (rdy_out && resp == RSP_OKAY));

   // R5: a transfer that is not accepted ignores err_req
   p_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_out && !accept_port) |=> (rdy_out && resp == RSP_OKAY));

   // R4: a released ERROR cycle is always preceded by a low ready
   p_err_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_out && resp == RSP_ERR) |-> $past(!rdy_out));

endmodule

// File: tb/test_ahb_errresp_ctrl.sv
module test_ahb_errresp_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0;
   logic [1:0] trans = 2'b00;
   logic       rdy_in = 1'b1;
   logic       err_req = 1'b0;
   logic       rdy_out;
   logic [0:0] resp;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   int mstate  = 0;   // 0 okay, 1 first error cycle, 2 second error cycle

   always #10 clk = ~clk;   // 50 MHz

   ahb_errresp_ctrl i_ahb_errresp_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .trans   (trans),
      .rdy_in  (rdy_in),
      .err_req (err_req),
      .rdy_out (rdy_out),
      .resp    (resp)
   );

   task automatic check(input string tag, input logic exp_rdy, input logic exp_rsp);
      n_tests++;
      if (rdy_out !== exp_rdy || resp !== exp_rsp) begin
         n_fail++;
         $display("FAIL %s: rdy_out=%b resp=%b expected rdy_out=%b resp=%b",
                  tag, rdy_out, resp, exp_rdy, exp_rsp);
      end
   endtask

   // Drive one cycle of inputs, then compare against the requirement model.
   task automatic step(input logic s, input logic [1:0] t, input logic r, input logic e);
      string tag;
      bit    acc;
      int    nxt;
      acc = s && (t == 2'b10 || t == 2'b11) && r && (mstate != 1);
      if (mstate == 1)      tag = "R7 R4";
      else if (!acc)        tag = "R5";
      else if (mstate == 2) tag = e ? "R6 R3 R8" : "R6 R2";
      else                  tag = e ? "R3 R8" : "R2";
      if (mstate == 1)   nxt = 2;
      else if (acc && e) nxt = 1;
      else               nxt = 0;
      sel = s; trans = t; rdy_in = r; err_req = e;
      @(posedge clk);
      @(negedge clk);
      mstate = nxt;
      check(tag, (nxt != 1), (nxt != 0));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (2) @(negedge clk);
      check("R1", 1'b1, 1'b0);          // during reset
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 R8", 1'b1, 1'b0);       // first cycle after reset
      mstate = 0;

      for (int pre = 0; pre < 3; pre++) begin
         for (int c = 0; c < 32; c++) begin
            step(1'b0, 2'b00, 1'b1, 1'b0);
            step(1'b0, 2'b00, 1'b1, 1'b0);
            if (pre >= 1) step(1'b1, 2'b10, 1'b1, 1'b1);   // into first error cycle
            if (pre == 2) step(1'b0, 2'b00, 1'b0, 1'b0);   // into second error cycle
            step(c[4], c[3:2], c[1], c[0]);                // swept combination
            step(1'b0, 2'b00, 1'b1, 1'b0);
         end
      end

      // back-to-back errors on a SEQ burst, released in the second cycle each time
      for (int k = 0; k < 4; k++) begin
         step(1'b1, 2'b11, 1'b1, 1'b1);
         step(1'b1, 2'b11, 1'b0, 1'b1);
      end
      step(1'b0, 2'b00, 1'b1, 1'b0);
      step(1'b0, 2'b00, 1'b1, 1'b0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule